// File: doc/BRIEF.md
# Port Command Slot Tracker

This block keeps the per-slot command bookkeeping for one port of a serial storage host controller with a parameterised number of command slots (32 by default). Software posts commands by setting bits in an issue vector and, for queued (native command queueing) commands, also in an active vector before issuing. While the port is running, the tracker hands the lowest-numbered issued slot to a device engine, one command at a time. It then clears issue and active bits according to the frames the engine reports back from the device.

Two kinds of received frame are handled: a device-to-host register frame (interrupt flag, status byte, error byte) and a set-device-bits frame (interrupt flag, status byte, error byte, mask of queued tags that finished cleanly). From these the block keeps a shadow of the device task-file status and error, raises the port interrupt status bits and stops dispatching after an error until software stops the port. An abort request from the engine loads the abort status into the shadow and signals a transfer stop one cycle after the status has been written.

A command is queued when its active bit is set at the moment it is dispatched. A queued command leaves flight at the first register frame after dispatch, which is its queue acceptance. A non-queued command leaves flight at the register frame that shows the device no longer busy.

Top module: `port_slot_tracker`

## Requirements
- R1: A start write of 0 while the port is running clears the issue vector, the active vector, the in-flight command and the error halt on that clock edge, overriding any set or clear arriving in the same cycle.
- R2: Writes to the issue and active vectors OR their data into the vector, and are ignored while the start bit as held before that cycle is 0.
- R3: One clock after the port is running, not halted, has no command in flight, has a non-zero issue vector and has status bits BSY (bit 7) and DRQ (bit 3) clear in the shadow, `disp_valid` pulses for one cycle with `disp_slot` set to the lowest set issue bit; the slot stays in flight until it is retired.
- R4: A register frame that arrives while a non-queued command is in flight retires it when BSY and DRQ are clear; its issue bit is cleared only if ERR (bit 0) is also clear, otherwise it stays set.
- R5: A register frame that arrives while a queued command is in flight retires it, and clears its issue bit only if ERR, BSY and DRQ are all clear; its active bit is untouched.
- R6: A command retired with ERR set halts dispatch until a start write of 0 is made.
- R7: A register frame sets interrupt status bit 2 (task-file error) when its ERR bit is 1, and bit 0 (register frame received) only when its interrupt flag is 1.
- R8: A set-device-bits frame with ERR set sets interrupt status bit 2 and never bit 1; without ERR it sets bit 1 (set-device-bits received) only when its interrupt flag is 1.
- R9: A set-device-bits frame clears exactly the active bits named in its done mask; other active bits keep their value.
- R10: An abort request loads status 0x41 and error 0x04 into the shadow on the next edge, and `xfer_stop` pulses one cycle after that.
- R11: Interrupt status bits are cleared by writing 1, a new event in the same cycle wins over the clear, and `irq_o` is the OR of status AND enable, registered one cycle behind the status.
- R12: `list_running` is 1 from one cycle after start is 1, and falls one cycle after start is 0 and no command is in flight.
- R13: The shadow status and error take the bytes of the latest frame, with abort over register frame over set-device-bits frame when they coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_we | input | 1 | Start bit write strobe |
| start_val | input | 1 | Start bit write value |
| issue_we | input | 1 | Issue vector write strobe |
| issue_data | input | N | Bits to OR into the issue vector |
| active_we | input | 1 | Active vector write strobe |
| active_data | input | N | Bits to OR into the active vector |
| irq_clr_we | input | 1 | Interrupt status clear strobe |
| irq_clr_data | input | 3 | Write-1-to-clear mask |
| irq_en | input | 3 | Interrupt enable per status bit |
| d2h_valid | input | 1 | Register frame received |
| d2h_ibit | input | 1 | Register frame interrupt flag |
| d2h_status | input | 8 | Register frame status byte |
| d2h_error | input | 8 | Register frame error byte |
| sdb_valid | input | 1 | Set-device-bits frame received |
| sdb_ibit | input | 1 | Set-device-bits interrupt flag |
| sdb_status | input | 8 | Set-device-bits status byte |
| sdb_error | input | 8 | Set-device-bits error byte |
| sdb_done | input | N | Queued tags finished without error |
| eng_abort | input | 1 | Engine aborts the current command |
| issue_vec | output | N | Command issue vector |
| active_vec | output | N | Active (queued) vector |
| disp_valid | output | 1 | Dispatch pulse |
| disp_slot | output | SW | Dispatched slot number |
| list_running | output | 1 | Command list running flag |
| irq_sts | output | 3 | Interrupt status: bit 0 register frame, bit 1 set-device-bits, bit 2 task-file error |
| irq_o | output | 1 | Port interrupt |
| tf_status | output | 8 | Shadow device status |
| tf_error | output | 8 | Shadow device error |
| xfer_stop | output | 1 | Transfer stop pulse after abort |

## Verification
Two pairs of functions can land on the same edge: a register frame retiring the in-flight slot while software sets a different issue bit, and a frame raising an interrupt status bit while software clears that same bit. The bench drives each pair in one cycle on purpose and expects the retired bit gone, the new bit present and the interrupt bit still set. Random traffic then mixes writes, frames, aborts and start drops freely, and every output is compared each cycle against a bench model built from the requirements.

// File: rtl/slot_trk_pkg.sv
package slot_trk_pkg;
  // device status byte bit positions
  localparam int ST_ERR  = 0;
  localparam int ST_DRQ  = 3;
  localparam int ST_DRDY = 6;
  localparam int ST_BSY  = 7;

  // port interrupt status layout
  localparam int IRQ_W   = 3;
  localparam int IRQ_DHR = 0;
  localparam int IRQ_SDB = 1;
  localparam int IRQ_TFE = 2;

  localparam logic [7:0] ABORT_STATUS = 8'((1 << ST_DRDY) | (1 << ST_ERR));
  localparam logic [7:0] ABORT_ERROR  = 8'h04;

  typedef logic [IRQ_W-1:0] irq_vec_t;
endpackage

// File: rtl/slot_pick.sv
module slot_pick #(
  parameter int N  = 32,
  parameter int SW = 5
)(
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [SW-1:0] idx
);
  // lowest set bit wins: scan down so the last hit is the smallest index
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = SW'(i);
    end
  end
endmodule

// File: rtl/slot_irq_unit.sv
module slot_irq_unit
  import slot_trk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t set_i,
  input  irq_vec_t clr_i,
  input  irq_vec_t en_i,
  output irq_vec_t sts_o,
  output logic     irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_o <= '0;
      irq_o <= 1'b0;
    end else begin
      sts_o <= (sts_o & ~clr_i) | set_i;
      irq_o <= |(sts_o & en_i);
    end
  end
endmodule

// File: rtl/slot_tf_shadow.sv
module slot_tf_shadow
  import slot_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       abort_i,
  input  logic       d2h_valid,
  input  logic [7:0] d2h_status,
  input  logic [7:0] d2h_error,
  input  logic       sdb_valid,
  input  logic [7:0] sdb_status,
  input  logic [7:0] sdb_error,
  output logic [7:0] status_o,
  output logic [7:0] error_o,
  output logic       stop_o
);
  logic abort_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      error_o  <= '0;
      abort_d  <= 1'b0;
      stop_o   <= 1'b0;
    end else begin
      abort_d <= abort_i;
      stop_o  <= abort_d;
      if (abort_i) begin
        status_o <= ABORT_STATUS;
        error_o  <= ABORT_ERROR;
      end else if (d2h_valid) begin
        status_o <= d2h_status;
        error_o  <= d2h_error;
      end else if (sdb_valid) begin
        status_o <= sdb_status;
        error_o  <= sdb_error;
      end
    end
  end
endmodule

// File: rtl/port_slot_tracker.sv
module port_slot_tracker
  import slot_trk_pkg::*;
#(
  parameter  int N  = 32,
  localparam int SW = (N > 1) ? $clog2(N) : 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_we,
  input  logic             start_val,
  input  logic             issue_we,
  input  logic [N-1:0]     issue_data,
  input  logic             active_we,
  input  logic [N-1:0]     active_data,
  input  logic             irq_clr_we,
  input  logic [IRQ_W-1:0] irq_clr_data,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic             d2h_valid,
  input  logic             d2h_ibit,
  input  logic [7:0]       d2h_status,
  input  logic [7:0]       d2h_error,
  input  logic             sdb_valid,
  input  logic             sdb_ibit,
  input  logic [7:0]       sdb_status,
  input  logic [7:0]       sdb_error,
  input  logic [N-1:0]     sdb_done,
  input  logic             eng_abort,
  output logic [N-1:0]     issue_vec,
  output logic [N-1:0]     active_vec,
  output logic             disp_valid,
  output logic [SW-1:0]    disp_slot,
  output logic             list_running,
  output logic [IRQ_W-1:0] irq_sts,
  output logic             irq_o,
  output logic [7:0]       tf_status,
  output logic [7:0]       tf_error,
  output logic             xfer_stop
);
  logic          start_q;
  logic          halted_q;
  logic          infl_q;
  logic          infl_queued_q;
  logic [SW-1:0] infl_slot_q;

  logic          pick_found;
  logic [SW-1:0] pick_idx;
  logic          stop_run;
  logic          go;
  logic          frame_hits;
  logic          frame_busy;
  logic          retire;
  logic          clr_issue;
  logic [N-1:0]  slot_oh;
  irq_vec_t      irq_set;
  irq_vec_t      irq_clr;

  slot_pick #(.N(N), .SW(SW)) u_pick (
    .vec   (issue_vec),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign stop_run   = start_we & ~start_val & start_q;
  assign go         = start_q & ~halted_q & ~infl_q & pick_found &
                      ~tf_status[ST_BSY] & ~tf_status[ST_DRQ] & ~stop_run;
  assign frame_hits = d2h_valid & infl_q;
  assign frame_busy = d2h_status[ST_BSY] | d2h_status[ST_DRQ];
  assign retire     = frame_hits & (infl_queued_q | ~frame_busy);
  assign clr_issue  = frame_hits & ~frame_busy & ~d2h_status[ST_ERR];
  assign slot_oh    = N'(1) << infl_slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q       <= 1'b0;
      halted_q      <= 1'b0;
      infl_q        <= 1'b0;
      infl_queued_q <= 1'b0;
      infl_slot_q   <= '0;
      issue_vec     <= '0;
      active_vec    <= '0;
      disp_valid    <= 1'b0;
      disp_slot     <= '0;
      list_running  <= 1'b0;
    end else begin
      start_q      <= start_we ? start_val : start_q;
      list_running <= start_q | infl_q;
      disp_valid   <= go;
      if (go) begin
        disp_slot     <= pick_idx;
        infl_slot_q   <= pick_idx;
        infl_queued_q <= active_vec[pick_idx];
      end
      if (stop_run) begin
        issue_vec  <= '0;
        active_vec <= '0;
        halted_q   <= 1'b0;
        infl_q     <= 1'b0;
      end else begin
        issue_vec  <= (issue_vec | ((issue_we && start_q) ? issue_data : '0)) &
                      ~(clr_issue ? slot_oh : '0);
        active_vec <= (active_vec | ((active_we && start_q) ? active_data : '0)) &
                      ~(sdb_valid ? sdb_done : '0);
        if (retire && d2h_status[ST_ERR]) halted_q <= 1'b1;
        if (go)          infl_q <= 1'b1;
        else if (retire) infl_q <= 1'b0;
      end
    end
  end

  // error in a set-device-bits frame overrides its interrupt flag
  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_DHR] = d2h_valid & d2h_ibit;
    irq_set[IRQ_SDB] = sdb_valid & ~sdb_status[ST_ERR] & sdb_ibit;
    irq_set[IRQ_TFE] = (d2h_valid & d2h_status[ST_ERR]) |
                       (sdb_valid & sdb_status[ST_ERR]);
    irq_clr          = irq_clr_we ? irq_clr_data : '0;
  end

  slot_irq_unit u_irq (
    .clk   (clk),
    .rst   (rst),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .en_i  (irq_en),
    .sts_o (irq_sts),
    .irq_o (irq_o)
  );

  slot_tf_shadow u_tf (
    .clk        (clk),
    .rst        (rst),
    .abort_i    (eng_abort),
    .d2h_valid  (d2h_valid),
    .d2h_status (d2h_status),
    .d2h_error  (d2h_error),
    .sdb_valid  (sdb_valid),
    .sdb_status (sdb_status),
    .sdb_error  (sdb_error),
    .status_o   (tf_status),
    .error_o    (tf_error),
    .stop_o     (xfer_stop)
  );
endmodule

// File: rtl/slot_tracker_chk.sv
module slot_tracker_chk
  import slot_trk_pkg::*;
#(
  parameter  int N  = 32,
  localparam int SW = (N > 1) ? $clog2(N) : 1
)(
  input logic             clk,
  input logic             rst,
  input logic             start_we,
  input logic             start_val,
  input logic             d2h_valid,
  input logic [7:0]       d2h_status,
  input logic             sdb_valid,
  input logic [7:0]       sdb_status,
  input logic             eng_abort,
  input logic [N-1:0]     issue_vec,
  input logic [N-1:0]     active_vec,
  input logic             disp_valid,
  input logic [SW-1:0]    disp_slot,
  input logic [IRQ_W-1:0] irq_sts,
  input logic             xfer_stop
);
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(start_we && !start_val) |-> (issue_vec == '0 && active_vec == '0)); // R1

  AST_DISP_PULSE: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid); // R3

  AST_DISP_ISSUED: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> issue_vec[disp_slot]); // R3

  AST_D2H_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (d2h_valid && d2h_status[ST_ERR]) |=> irq_sts[IRQ_TFE]); // R7

  AST_SDB_ERR_NO_SDBS: assert property (@(posedge clk) disable iff (rst)
    (sdb_valid && sdb_status[ST_ERR] && !irq_sts[IRQ_SDB]) |=> !irq_sts[IRQ_SDB]); // R8

  AST_STOP_AFTER_ABORT: assert property (@(posedge clk) disable iff (rst)
    xfer_stop |-> $past(eng_abort, 2)); // R10
endmodule

bind port_slot_tracker slot_tracker_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_we   (start_we),
  .start_val  (start_val),
  .d2h_valid  (d2h_valid),
  .d2h_status (d2h_status),
  .sdb_valid  (sdb_valid),
  .sdb_status (sdb_status),
  .eng_abort  (eng_abort),
  .issue_vec  (issue_vec),
  .active_vec (active_vec),
  .disp_valid (disp_valid),
  .disp_slot  (disp_slot),
  .irq_sts    (irq_sts),
  .xfer_stop  (xfer_stop)
);

// File: tb/tb_port_slot_tracker.sv
module tb_port_slot_tracker;
  import slot_trk_pkg::*;
  localparam int N  = 32;
  localparam int SW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic start_we, start_val, issue_we, active_we, irq_clr_we;
  logic [N-1:0] issue_data, active_data, sdb_done;
  logic [2:0] irq_clr_data, irq_en;
  logic d2h_valid, d2h_ibit, sdb_valid, sdb_ibit, eng_abort;
  logic [7:0] d2h_status, d2h_error, sdb_status, sdb_error;
  logic [N-1:0] issue_vec, active_vec;
  logic disp_valid, list_running, irq_o, xfer_stop;
  logic [SW-1:0] disp_slot;
  logic [2:0] irq_sts;
  logic [7:0] tf_status, tf_error;

  port_slot_tracker #(.N(N)) dut (.*);

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic m_start, m_halt, m_infl, m_inflq, m_disp, m_cr, m_irq, m_ab, m_xs;
  int m_slot, m_dslot;
  logic [N-1:0] m_issue, m_active;
  logic [2:0] m_sts;
  logic [7:0] m_st, m_er;

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin : model
    logic fall, go, hits, busy, ends, clr;
    logic [2:0] setv;
    logic [N-1:0] one;
    int lo;
    logic newq;
    if (rst) begin
      m_start = 0; m_halt = 0; m_infl = 0; m_inflq = 0; m_disp = 0; m_cr = 0;
      m_irq = 0; m_ab = 0; m_xs = 0; m_slot = 0; m_dslot = 0;
      m_issue = 0; m_active = 0; m_sts = 0; m_st = 0; m_er = 0;
    end else begin
      one  = 1;
      fall = start_we && !start_val && m_start;
      go   = m_start && !m_halt && !m_infl && (m_issue != 0) && !m_st[7] && !m_st[3] && !fall;
      lo   = lowest(m_issue);
      newq = m_active[lo];
      hits = d2h_valid && m_infl;
      busy = d2h_status[7] || d2h_status[3];
      ends = hits && (m_inflq || !busy);
      clr  = hits && !busy && !d2h_status[0];
      setv = 3'b000;
      if (d2h_valid && d2h_ibit) setv[0] = 1'b1;
      if (d2h_valid && d2h_status[0]) setv[2] = 1'b1;
      if (sdb_valid) begin
        if (sdb_status[0]) setv[2] = 1'b1;
        else if (sdb_ibit) setv[1] = 1'b1;
      end
      m_irq = |(m_sts & irq_en);
      m_sts = (m_sts & ~(irq_clr_we ? irq_clr_data : 3'b000)) | setv;
      m_cr  = m_start || m_infl;
      m_xs  = m_ab;
      m_ab  = eng_abort;
      if (eng_abort) begin m_st = 8'h41; m_er = 8'h04; end
      else if (d2h_valid) begin m_st = d2h_status; m_er = d2h_error; end
      else if (sdb_valid) begin m_st = sdb_status; m_er = sdb_error; end
      m_disp = go;
      if (go) m_dslot = lo;
      if (fall) begin
        m_issue = 0; m_active = 0; m_halt = 0; m_infl = 0;
      end else begin
        m_issue  = (m_issue | ((issue_we && m_start) ? issue_data : '0)) & ~(clr ? (one << m_slot) : '0);
        m_active = (m_active | ((active_we && m_start) ? active_data : '0)) & ~(sdb_valid ? sdb_done : '0);
        if (ends && d2h_status[0]) m_halt = 1;
        if (go) begin m_infl = 1; m_inflq = newq; m_slot = lo; end
        else if (ends) m_infl = 0;
      end
      if (start_we) m_start = start_val;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      cmp("R1/R2/R4/R5 issue_vec", 64'(issue_vec), 64'(m_issue));
      cmp("R2/R9 active_vec", 64'(active_vec), 64'(m_active));
      cmp("R3/R6 disp_valid", 64'(disp_valid), 64'(m_disp));
      if (m_disp) cmp("R3 disp_slot", 64'(disp_slot), 64'(m_dslot));
      cmp("R12 list_running", 64'(list_running), 64'(m_cr));
      cmp("R7/R8/R11 irq_sts", 64'(irq_sts), 64'(m_sts));
      cmp("R11 irq_o", 64'(irq_o), 64'(m_irq));
      cmp("R13 tf_status", 64'(tf_status), 64'(m_st));
      cmp("R10/R13 tf_error", 64'(tf_error), 64'(m_er));
      cmp("R10 xfer_stop", 64'(xfer_stop), 64'(m_xs));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    start_we = 0; start_val = 0; issue_we = 0; issue_data = '0;
    active_we = 0; active_data = '0; irq_clr_we = 0; irq_clr_data = '0;
    d2h_valid = 0; d2h_ibit = 0; d2h_status = '0; d2h_error = '0;
    sdb_valid = 0; sdb_ibit = 0; sdb_status = '0; sdb_error = '0; sdb_done = '0;
    eng_abort = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic step();
    tick();
    idle();
  endtask

  task automatic d2h(input logic ib, input logic [7:0] st, input logic [7:0] er);
    d2h_valid = 1; d2h_ibit = ib; d2h_status = st; d2h_error = er;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (timeout) act=running exp=done");
    report();
  end

  function automatic logic [7:0] pick_status(input int k);
    case (k % 7)
      0: return 8'h40;
      1: return 8'h41;
      2: return 8'h80;
      3: return 8'h48;
      4: return 8'h50;
      5: return 8'h01;
      default: return 8'h58;
    endcase
  endfunction

  initial begin : main
    void'($urandom(32'd20240611));
    idle();
    irq_en = 3'b000;
    rst = 1;
    repeat (4) tick();
    rst = 0;
    cmp_on = 1;
    tick();
    cmp("R12 reset list_running", 64'(list_running), 0);
    cmp("R11 reset irq_sts", 64'(irq_sts), 0);
    cmp("R1 reset issue_vec", 64'(issue_vec), 0);

    // R2: issue ignored while stopped
    issue_we = 1; issue_data = 32'hFF; step();
    cmp("R2 issue ignored while stopped", 64'(issue_vec), 0);

    start_we = 1; start_val = 1; step();
    tick();
    cmp("R12 running after start", 64'(list_running), 1);

    issue_we = 1; issue_data = 32'h12; step();
    cmp("R2 issue OR", 64'(issue_vec), 64'h12);
    tick();
    cmp("R3 dispatch pulse", 64'(disp_valid), 1);
    cmp("R3 lowest slot", 64'(disp_slot), 1);
    tick();
    cmp("R3 single pulse", 64'(disp_valid), 0);

    // R4: clean completion of non-queued slot 1
    d2h(1, 8'h40, 8'h00); step();
    cmp("R4 clean retire clears issue", 64'(issue_vec), 64'h10);
    cmp("R7 DHR set by flag", 64'(irq_sts), 3'b001);
    tick();
    cmp("R3 next slot dispatched", 64'(disp_slot), 4);

    // R4/R6: error completion of slot 4
    d2h(1, 8'h41, 8'h04); step();
    cmp("R4 error keeps issue bit", 64'(issue_vec), 64'h10);
    cmp("R7 error raises TFE", 64'(irq_sts), 3'b101);
    cmp("R13 status follows frame", 64'(tf_status), 64'h41);
    for (int i = 0; i < 3; i++) begin
      tick();
      cmp("R6 halted no dispatch", 64'(disp_valid), 0);
    end

    irq_en = 3'b111; tick();
    cmp("R11 irq output", 64'(irq_o), 1);
    irq_clr_we = 1; irq_clr_data = 3'b111; step();
    cmp("R11 W1C clears", 64'(irq_sts), 0);
    tick();
    cmp("R11 irq output drops", 64'(irq_o), 0);

    // R1: stop clears vectors
    start_we = 1; start_val = 0; step();
    cmp("R1 stop clears issue", 64'(issue_vec), 0);
    tick();
    cmp("R12 running drops", 64'(list_running), 0);

    // R5: queued command
    start_we = 1; start_val = 1; step();
    active_we = 1; active_data = 32'h8; issue_we = 1; issue_data = 32'h8; step();
    tick();
    cmp("R3 queued slot dispatched", 64'(disp_slot), 3);
    d2h(0, 8'h40, 8'h00); step();
    cmp("R5 accept clears issue", 64'(issue_vec), 0);
    cmp("R5 accept keeps active", 64'(active_vec), 64'h8);
    cmp("R7 no DHR without flag", 64'(irq_sts), 0);

    // R8/R9: set-device-bits frames
    sdb_valid = 1; sdb_ibit = 1; sdb_status = 8'h40; sdb_done = 32'h8; step();
    cmp("R9 done tag cleared", 64'(active_vec), 0);
    cmp("R8 SDB flag", 64'(irq_sts), 3'b010);
    active_we = 1; active_data = 32'h6; irq_clr_we = 1; irq_clr_data = 3'b111; step();
    sdb_valid = 1; sdb_ibit = 1; sdb_status = 8'h41; sdb_done = 32'h2; step();
    cmp("R9 failed tag stays", 64'(active_vec), 64'h4);
    cmp("R8 error overrides flag", 64'(irq_sts), 3'b100);

    // R10: abort
    eng_abort = 1; step();
    cmp("R10 abort status", 64'(tf_status), 64'h41);
    cmp("R10 abort error", 64'(tf_error), 64'h04);
    cmp("R10 stop not yet", 64'(xfer_stop), 0);
    tick();
    cmp("R10 stop pulse", 64'(xfer_stop), 1);
    tick();
    cmp("R10 stop ends", 64'(xfer_stop), 0);

    d2h(0, 8'h50, 8'h00); step();
    cmp("R13 shadow status", 64'(tf_status), 64'h50);
    cmp("R13 shadow error", 64'(tf_error), 0);

    // R3: BSY in shadow blocks dispatch
    d2h(0, 8'h80, 8'h00); step();
    issue_we = 1; issue_data = 32'h1; step();
    for (int i = 0; i < 3; i++) begin
      tick();
      cmp("R3 BSY blocks dispatch", 64'(disp_valid), 0);
    end
    d2h(0, 8'h40, 8'h00); step();
    tick();
    cmp("R3 dispatch after BSY clears", 64'(disp_valid), 1);
    cmp("R3 slot 0", 64'(disp_slot), 0);

    // same-cycle: retire slot 0 + issue slot 5 + clear DHR while it is set again
    d2h(1, 8'h40, 8'h00);
    issue_we = 1; issue_data = 32'h20;
    irq_clr_we = 1; irq_clr_data = 3'b001;
    step();
    cmp("R4 retire with concurrent issue", 64'(issue_vec), 64'h20);
    cmp("R11 set wins over clear", 64'(irq_sts[0]), 1);

    // random traffic, compared against model every cycle
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom % 100);
      if (($urandom % 100) < 3) begin start_we = 1; start_val = (($urandom % 4) != 0); end
      if (($urandom % 100) < 20) begin
        issue_we = 1; issue_data = (N'(1) << ($urandom % N)) | (N'(1) << ($urandom % N));
      end
      if (($urandom % 100) < 10) begin active_we = 1; active_data = N'(1) << ($urandom % N); end
      if (($urandom % 100) < 10) begin irq_clr_we = 1; irq_clr_data = 3'($urandom); end
      if ((c % 50) == 0) irq_en = 3'($urandom);
      if (r < 25) d2h(1'($urandom), pick_status(int'($urandom % 7)), 8'($urandom));
      else if (r < 35) begin
        sdb_valid = 1; sdb_ibit = 1'($urandom);
        sdb_status = pick_status(int'($urandom % 7)); sdb_error = 8'($urandom);
        sdb_done = N'($urandom);
      end else if (r < 37) eng_abort = 1;
      step();
    end

    repeat (3) tick();
    report();
  end
endmodule